// File: doc/BRIEF.md
# Block I/O Transfer Engine

This block moves bytes between memory and an I/O port, one byte per step. A run is started by a one-cycle `start` pulse. The pulse carries an 8-bit transfer count, an 8-bit port low byte and a 16-bit memory pointer. Three control inputs complete the request:

- `isOutput` selects the direction of the transfer: port-to-memory or memory-to-port.
- `dirDown` selects whether the pointer counts down or up.
- `repeatEn` selects whether the run stops after one step or keeps going until the count runs out.

The high byte of the 16-bit port address is always the live count register. As a result, an input step and an output step place different count values on the port address bus. An input step reads the port before the count drops. An output step decrements the count first, so its port write carries the new value.

After every step the engine rewrites the whole flag byte. It also keeps a running cost figure: a fixed number of cycles per step, plus an extra charge for every step that loops back for another iteration. Memory and port reads return data one cycle after the read strobe. Each step therefore takes two clock cycles: a fetch cycle followed by a move cycle.

Top module: `blk_io_xfer`

## Requirements
- R1: In an input step, `ioRd` is driven for one cycle with `ioAddr` = {B, C} using the undecremented B. The next cycle drives `memWr` with `memAddr` = HL and `memWdata` equal to the byte that the port returned.
- R2: In an output step, `memRd` is driven at address HL. The next cycle drives `ioWr` with `ioWdata` equal to the memory byte and `ioAddr` = {B-1, C}, so the port sees the already-decremented count.
- R3: After each step HL changes by one, modulo 2^16. It moves up when `dirDown` was 0 at start and down when it was 1.
- R4: Each step lowers B by one, modulo 256. C keeps the value loaded at start for the whole run.
- R5: After each step, `flags` is exactly 0x02 (bit 1 set, all other bits clear). When the new B is zero, `flags` is exactly 0x42 (bit 6 also set). Reset value is 0x00.
- R6: With `repeatEn` = 0 a run is one step. With `repeatEn` = 1 the run continues while the decremented B is nonzero. `repPending` is high during the two cycles of every step after the first, and `done` pulses for one cycle only after the last step.
- R7: A starting B of 0 gives 256 steps when repeating and leaves B at 0.
- R8: `cycleCount` is cleared at start. It grows by STEP_COST for every step, plus REPEAT_COST for every step that is followed by another.
- R9: `memWr` and `ioWr` are single-cycle pulses, never high together. Each step produces exactly one of them.
- R10: A `start` pulse that arrives while a run is in progress is ignored. Registers, direction and mode keep the values of the running request.
- R11: While reset is held, the strobes, `done`, `repPending`, `flags`, `cycleCount` and the register outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run request, taken only when idle |
| isOutput | input | 1 | 1 = memory to port, 0 = port to memory |
| dirDown | input | 1 | 1 = pointer decrements, 0 = increments |
| repeatEn | input | 1 | 1 = loop until count reaches zero |
| bIn | input | 8 | Initial count (port address high byte) |
| cIn | input | 8 | Port address low byte |
| hlIn | input | 16 | Initial memory pointer |
| memAddr | output | 16 | Memory address |
| memRd | output | 1 | Memory read strobe |
| memRdata | input | 8 | Memory read data, valid one cycle after `memRd` |
| memWr | output | 1 | Memory write strobe |
| memWdata | output | 8 | Memory write data |
| ioAddr | output | 16 | Port address {B, C} |
| ioRd | output | 1 | Port read strobe |
| ioRdata | input | 8 | Port read data, valid one cycle after `ioRd` |
| ioWr | output | 1 | Port write strobe |
| ioWdata | output | 8 | Port write data |
| bOut | output | 8 | Current count |
| cOut | output | 8 | Current port low byte |
| hlOut | output | 16 | Current memory pointer |
| flags | output | 8 | Flag byte |
| done | output | 1 | One-cycle pulse after the final step |
| repPending | output | 1 | High while a repeated step is under way |
| cycleCount | output | 16 | Accumulated cost of the run |

## Verification
The bench sweeps starting counts that hit the interesting corners: 0, 1, 2, 3, 7, 128 and 255. Each count runs in both directions, with both pointer senses, in single-step and repeat modes, and with pointers placed to wrap across 0x0000/0xFFFF.

The port address of every output write is compared against the decremented count. A design that used the old count there would address the neighbouring port. The bench also checks that a start count of zero produces 256 transfers. A design that tested for zero before decrementing would stop after one step with a wrong flag byte.

Flags are compared as a whole byte, so a design that merged new flags with old ones would be caught by stray bits. The cost figure checks the extra charge per repeated step, and a second start is pulsed mid-run to show that it is ignored.

// File: rtl/blk_io_pkg.sv
package blk_io_pkg;

  localparam int FLAG_N_BIT = 1;
  localparam int FLAG_Z_BIT = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_MOVE  = 2'd2
  } xferState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture request registers
    logic fetch;  // issue the read of this step
    logic move;   // issue the write and commit the step
  } xferStrobe_t;

endpackage

// File: rtl/blk_io_ctrl.sv
module blk_io_ctrl
  import blk_io_pkg::*;
#(
  parameter int CYC_W       = 16,
  parameter int STEP_COST   = 16,
  parameter int REPEAT_COST = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             repeatEn,
  input  logic             bLast,
  output xferStrobe_t      strobe,
  output logic             done,
  output logic             repPending,
  output logic [CYC_W-1:0] cycleCount
);

  localparam logic [CYC_W-1:0] STEP_INC  = CYC_W'(STEP_COST);
  localparam logic [CYC_W-1:0] AGAIN_INC = CYC_W'(STEP_COST + REPEAT_COST);

  xferState_t state;
  logic       repMode;
  logic       again;

  assign again = repMode && !bLast;

  always_comb begin
    strobe       = '0;
    strobe.load  = (state == ST_IDLE) && start;
    strobe.fetch = (state == ST_FETCH);
    strobe.move  = (state == ST_MOVE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      repMode    <= 1'b0;
      done       <= 1'b0;
      repPending <= 1'b0;
      cycleCount <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            repMode    <= repeatEn;
            repPending <= 1'b0;
            cycleCount <= '0;
            state      <= ST_FETCH;
          end
        end
        ST_FETCH: state <= ST_MOVE;
        ST_MOVE: begin
          if (again) begin
            repPending <= 1'b1;
            cycleCount <= cycleCount + AGAIN_INC;
            state      <= ST_FETCH;
          end else begin
            repPending <= 1'b0;
            done       <= 1'b1;
            cycleCount <= cycleCount + STEP_INC;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/blk_io_dp.sv
module blk_io_dp
  import blk_io_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PORT_W = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int IO_AW = CNT_W + PORT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  xferStrobe_t       strobe,
  input  logic              isOutput,
  input  logic              dirDown,
  input  logic [CNT_W-1:0]  bIn,
  input  logic [PORT_W-1:0] cIn,
  input  logic [ADDR_W-1:0] hlIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  output logic [IO_AW-1:0]  ioAddr,
  output logic              ioRd,
  input  logic [DATA_W-1:0] ioRdata,
  output logic              ioWr,
  output logic [DATA_W-1:0] ioWdata,
  output logic [CNT_W-1:0]  bOut,
  output logic [PORT_W-1:0] cOut,
  output logic [ADDR_W-1:0] hlOut,
  output logic [7:0]        flags,
  output logic              bLast
);

  localparam logic [CNT_W-1:0]  B_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] HL_ONE = ADDR_W'(1);

  logic [CNT_W-1:0]  bReg;
  logic [PORT_W-1:0] cReg;
  logic [ADDR_W-1:0] hlReg;
  logic [7:0]        flagReg;
  logic              outMode;
  logic              downMode;

  logic [CNT_W-1:0]  bDec;
  logic [ADDR_W-1:0] hlNext;
  logic [7:0]        flagNext;

  assign bDec   = bReg - B_ONE;
  assign bLast  = (bDec == '0);
  assign hlNext = downMode ? (hlReg - HL_ONE) : (hlReg + HL_ONE);

  always_comb begin
    flagNext             = '0;
    flagNext[FLAG_N_BIT] = 1'b1;
    flagNext[FLAG_Z_BIT] = bLast;
  end

  // Bus drive: output writes carry the decremented count
  always_comb begin
    memRd    = strobe.fetch &  outMode;
    ioRd     = strobe.fetch & ~outMode;
    memWr    = strobe.move  & ~outMode;
    ioWr     = strobe.move  &  outMode;
    memAddr  = hlReg;
    memWdata = ioRdata;
    ioWdata  = memRdata;
    ioAddr   = {(outMode && strobe.move) ? bDec : bReg, cReg};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bReg     <= '0;
      cReg     <= '0;
      hlReg    <= '0;
      flagReg  <= '0;
      outMode  <= 1'b0;
      downMode <= 1'b0;
    end else if (strobe.load) begin
      bReg     <= bIn;
      cReg     <= cIn;
      hlReg    <= hlIn;
      outMode  <= isOutput;
      downMode <= dirDown;
    end else if (strobe.move) begin
      bReg    <= bDec;
      hlReg   <= hlNext;
      flagReg <= flagNext;
    end
  end

  assign bOut  = bReg;
  assign cOut  = cReg;
  assign hlOut = hlReg;
  assign flags = flagReg;

endmodule

// File: rtl/blk_io_xfer.sv
module blk_io_xfer
  import blk_io_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PORT_W      = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int CYC_W       = 16,
  parameter int STEP_COST   = 16,
  parameter int REPEAT_COST = 5,
  localparam int IO_AW      = CNT_W + PORT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              isOutput,
  input  logic              dirDown,
  input  logic              repeatEn,
  input  logic [CNT_W-1:0]  bIn,
  input  logic [PORT_W-1:0] cIn,
  input  logic [ADDR_W-1:0] hlIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWr,
  output logic [DATA_W-1:0] memWdata,
  output logic [IO_AW-1:0]  ioAddr,
  output logic              ioRd,
  input  logic [DATA_W-1:0] ioRdata,
  output logic              ioWr,
  output logic [DATA_W-1:0] ioWdata,
  output logic [CNT_W-1:0]  bOut,
  output logic [PORT_W-1:0] cOut,
  output logic [ADDR_W-1:0] hlOut,
  output logic [7:0]        flags,
  output logic              done,
  output logic              repPending,
  output logic [CYC_W-1:0]  cycleCount
);

  xferStrobe_t strobe;
  logic        bLast;

  blk_io_ctrl #(
    .CYC_W(CYC_W), .STEP_COST(STEP_COST), .REPEAT_COST(REPEAT_COST)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .repeatEn(repeatEn),
    .bLast(bLast), .strobe(strobe), .done(done),
    .repPending(repPending), .cycleCount(cycleCount)
  );

  blk_io_dp #(
    .CNT_W(CNT_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .isOutput(isOutput),
    .dirDown(dirDown), .bIn(bIn), .cIn(cIn), .hlIn(hlIn),
    .memAddr(memAddr), .memRd(memRd), .memRdata(memRdata),
    .memWr(memWr), .memWdata(memWdata), .ioAddr(ioAddr), .ioRd(ioRd),
    .ioRdata(ioRdata), .ioWr(ioWr), .ioWdata(ioWdata), .bOut(bOut),
    .cOut(cOut), .hlOut(hlOut), .flags(flags), .bLast(bLast)
  );

endmodule

// File: rtl/blk_io_chk.sv
module blk_io_chk #(
  parameter int CNT_W  = 8,
  parameter int PORT_W = 8,
  parameter int ADDR_W = 16,
  localparam int IO_AW = CNT_W + PORT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              memRd,
  input logic              memWr,
  input logic              ioRd,
  input logic              ioWr,
  input logic [IO_AW-1:0]  ioAddr,
  input logic [CNT_W-1:0]  bOut,
  input logic [PORT_W-1:0] cOut,
  input logic [ADDR_W-1:0] hlOut,
  input logic [7:0]        flags,
  input logic              done,
  input logic              repPending
);

  localparam logic [ADDR_W-1:0] HL_ONE = ADDR_W'(1);

  assert_in_port_old_b_R1: assert property (@(posedge clk) disable iff (!rstN)
    ioRd |-> (ioAddr[IO_AW-1 -: CNT_W] == bOut));

  assert_in_then_mem_wr_R1: assert property (@(posedge clk) disable iff (!rstN)
    ioRd |=> memWr);

  assert_out_port_new_b_R2: assert property (@(posedge clk) disable iff (!rstN)
    ioWr |=> (bOut == $past(ioAddr[IO_AW-1 -: CNT_W])));

  assert_out_then_io_wr_R2: assert property (@(posedge clk) disable iff (!rstN)
    memRd |=> ioWr);

  assert_hl_unit_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memWr || ioWr) |=> ((hlOut == $past(hlOut) + HL_ONE) ||
                         (hlOut == $past(hlOut) - HL_ONE)));

  assert_c_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(cOut));

  assert_flag_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (flags == ((bOut == '0) ? 8'h42 : 8'h02)));

  assert_rep_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    repPending |-> (bOut != '0));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_io_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    ioWr |=> !ioWr);

  assert_mem_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> !memWr);

  assert_wr_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memWr && ioWr));

endmodule

bind blk_io_xfer blk_io_chk #(
  .CNT_W(CNT_W), .PORT_W(PORT_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .memRd(memRd), .memWr(memWr),
  .ioRd(ioRd), .ioWr(ioWr), .ioAddr(ioAddr), .bOut(bOut), .cOut(cOut),
  .hlOut(hlOut), .flags(flags), .done(done), .repPending(repPending)
);

// File: tb/blk_io_xfer_tb_top.sv
module blk_io_xfer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STEP = 11;
  localparam int REP  = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, isOutput = 1'b0, dirDown = 1'b0, repeatEn = 1'b0;
  logic [7:0]  bIn = '0, cIn = '0;
  logic [15:0] hlIn = '0;
  logic [15:0] memAddr, ioAddr;
  logic        memRd, memWr, ioRd, ioWr, done, repPending;
  logic [7:0]  memRdata = '0, memWdata, ioRdata = '0, ioWdata;
  logic [7:0]  bOut, cOut, flags;
  logic [15:0] hlOut, cycleCount;

  int nChecks = 0, nFail = 0, cycles = 0;
  int logN = 0, doneCnt = 0, repCnt = 0;
  logic        wrIo   [0:511];
  logic [15:0] wrAddr [0:511];
  logic [7:0]  wrData [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_io_xfer #(.STEP_COST(STEP), .REPEAT_COST(REP)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .isOutput(isOutput),
    .dirDown(dirDown), .repeatEn(repeatEn), .bIn(bIn), .cIn(cIn),
    .hlIn(hlIn), .memAddr(memAddr), .memRd(memRd), .memRdata(memRdata),
    .memWr(memWr), .memWdata(memWdata), .ioAddr(ioAddr), .ioRd(ioRd),
    .ioRdata(ioRdata), .ioWr(ioWr), .ioWdata(ioWdata), .bOut(bOut),
    .cOut(cOut), .hlOut(hlOut), .flags(flags), .done(done),
    .repPending(repPending), .cycleCount(cycleCount)
  );

  function automatic logic [7:0] memVal(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] ioVal(input logic [15:0] a);
    return 8'(a[7:0] + a[15:8] * 8'd7 + 8'h3C);
  endfunction

  // Bus models with one cycle of read latency
  always @(posedge clk) begin
    if (memRd) memRdata <= memVal(memAddr);
    if (ioRd)  ioRdata  <= ioVal(ioAddr);
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Write monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (memWr && ioWr) chk(1'b0, "R9 both write strobes", 1, 0);
      if (memWr && logN < 512) begin
        wrIo[logN] = 1'b0; wrAddr[logN] = memAddr; wrData[logN] = memWdata; logN++;
      end
      if (ioWr && logN < 512) begin
        wrIo[logN] = 1'b1; wrAddr[logN] = ioAddr; wrData[logN] = ioWdata; logN++;
      end
      if (done) doneCnt++;
      if (repPending) repCnt++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic runOne(input logic [7:0] b, input logic [7:0] c, input logic [15:0] hl,
                        input bit outM, input bit downM, input bit repM);
    int n;
    bit poke;
    logic [7:0]  bk, bF, fExp;
    logic [15:0] hk, hF, aExp;
    logic [7:0]  dExp;
    n = repM ? ((b == 0) ? 256 : int'(b)) : 1;
    poke = repM && (n >= 3);
    @(negedge clk);
    logN = 0; doneCnt = 0; repCnt = 0;
    bIn = b; cIn = c; hlIn = hl; isOutput = outM; dirDown = downM; repeatEn = repM;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin  // R10: second request during the run
      @(negedge clk);
      bIn = ~b; cIn = ~c; hlIn = ~hl; isOutput = !outM; dirDown = !downM;
      repeatEn = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCnt == 0) @(negedge clk);
    @(negedge clk);

    chk(logN == n, "R6/R7 transfer count", logN, n);
    for (int k = 0; k < n && k < logN; k++) begin
      bk = 8'(b - k);
      hk = downM ? 16'(hl - k) : 16'(hl + k);
      if (outM) begin
        aExp = {8'(bk - 1), c};
        dExp = memVal(hk);
        chk(wrIo[k] == 1'b1 && wrAddr[k] == aExp && wrData[k] == dExp,
            "R2 output write addr/data", {wrAddr[k], wrData[k]}, {aExp, dExp});
      end else begin
        aExp = hk;
        dExp = ioVal({bk, c});
        chk(wrIo[k] == 1'b0 && wrAddr[k] == aExp && wrData[k] == dExp,
            "R1 input write addr/data", {wrAddr[k], wrData[k]}, {aExp, dExp});
      end
    end
    bF = 8'(b - n);
    hF = downM ? 16'(hl - n) : 16'(hl + n);
    fExp = (bF == 0) ? 8'h42 : 8'h02;
    chk(bOut == bF, "R4/R7 final B", bOut, bF);
    chk(cOut == c, poke ? "R4/R10 C unchanged" : "R4 C unchanged", cOut, c);
    chk(hlOut == hF, "R3 final HL", hlOut, hF);
    chk(flags == fExp, "R5 flag byte", flags, fExp);
    chk(cycleCount == 16'(n * STEP + (n - 1) * REP), "R8 cycle count",
        cycleCount, n * STEP + (n - 1) * REP);
    chk(doneCnt == 1, "R6 done pulses", doneCnt, 1);
    chk(repCnt == 2 * (n - 1), "R6 repeat-pending cycles", repCnt, 2 * (n - 1));
  endtask

  initial begin
    logic [7:0] bList [0:6];
    bList[0] = 8'd0;   bList[1] = 8'd1;   bList[2] = 8'd2; bList[3] = 8'd3;
    bList[4] = 8'd7;   bList[5] = 8'd128; bList[6] = 8'd255;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(bOut == 0 && cOut == 0 && hlOut == 0, "R11 reset regs", {bOut, cOut, hlOut}, 0);
    chk(flags == 0 && cycleCount == 0, "R11 reset flags/count", {flags, cycleCount}, 0);
    chk(!memRd && !memWr && !ioRd && !ioWr && !done && !repPending,
        "R11 reset strobes", {memRd, memWr, ioRd, ioWr, done, repPending}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 7; i++)
      for (int m = 0; m < 8; m++)
        runOne(bList[i], 8'(8'h10 + i * 8 + m),
               m[1] ? ((i % 2 == 0) ? 16'h0001 : 16'h8000)
                    : ((i % 2 == 0) ? 16'hFFFE : 16'h4000),
               m[0], m[1], m[2]);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule